// File: doc/BRIEF.md
# In-band loopback code detector

This block watches one serial bit stream, taken from either the receive or the transmit path of a line interface. It looks for two repeating codes: an activate code and a deactivate code. Each code is programmed with its own length and content. It counts as present only while the stream repeats it with at most a small number of bit mismatches per fixed-size window of bits. A code is declared detected once it has stayed present for longer than a programmed time, which is measured in ticks of a millisecond strobe. The strobe can be sped up for simulation.

The thresholds depend on two mode inputs. With automatic loopback off, activate detection uses its own threshold. Deactivate detection uses one of two thresholds chosen by the framing mode (a 30 ms class for the E1 mode and a 40 ms class for the T1/J1 mode). With automatic loopback on, both codes use one long threshold (the 5.1 s class). The block then requests remote loopback when the activate code is detected on the receive path, or digital loopback when it is detected on the transmit path. A deactivate detection on the same path withdraws that request. Each detection status feeds a sticky interrupt flag with a selectable edge sense, a clear strobe and a mask, and the unmasked flags are combined into one interrupt output.

Top module: `inband_code_detector`

## Requirements
- R1: Length field encoding is 00 = 5 bits, 01 = 6 bits, 10 = 7 bits and 11 = 8 bits. The code is the low L bits of its 8-bit pattern input, and the line carries it most significant bit first, repeated. Any bit rotation of that sequence is acquired.
- R2: A window of WIN_BITS valid bits with at most MAX_ERRS mismatches is good. After a good window the block counts tick pulses. The status output reads 1 from the clock edge after the tick that raises the count above the threshold, and it holds while windows stay good.
- R3: A window with more than MAX_ERRS mismatches clears the status at that window's last bit and restarts the tick count. The comparison phase then slips by one bit, so a misaligned stream locks after at most L-1 failed windows.
- R4: With auto_lpbk = 0, the activate threshold is ACT_MS ticks. The deactivate threshold is DEACT_T1_MS ticks when e1_mode = 0 and DEACT_E1_MS ticks when e1_mode = 1.
- R5: With auto_lpbk = 1, both the activate and the deactivate thresholds are AUTO_MS ticks.
- R6: With auto_lpbk = 1, a rising activate status sets remote_lpbk when path_is_tx = 0, or digital_lpbk when path_is_tx = 1. A rising deactivate status clears the request for that path. With auto_lpbk = 0, both requests are 0 one cycle later.
- R7: irq_flags bit 0 follows the activate status and bit 1 follows the deactivate status. A flag is set by a rising status edge. When irq_any_edge = 1, a falling edge also sets it.
- R8: irq is 1 exactly when some irq_flags bit is 1 and the matching irq_mask bit is 0 (a mask bit of 1 blocks it).
- R9: An irq_clr bit clears its flag on the next edge. A set event on the same edge wins over the clear.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_valid | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial data from the selected path |
| path_is_tx | input | 1 | 0 = stream is from the receive path, 1 = from the transmit path |
| tick_ms | input | 1 | One-cycle time-base pulse, nominally 1 ms |
| act_len | input | 2 | Activate code length select |
| act_code | input | 8 | Activate code content |
| deact_len | input | 2 | Deactivate code length select |
| deact_code | input | 8 | Deactivate code content |
| e1_mode | input | 1 | Selects the E1 deactivate threshold |
| auto_lpbk | input | 1 | Enables the long thresholds and the loopback requests |
| irq_any_edge | input | 1 | 1 = any status transition sets a flag, 0 = rising edge only |
| irq_mask | input | 2 | Per-flag interrupt block |
| irq_clr | input | 2 | Per-flag clear strobe |
| act_status | output | 1 | Activate code detected |
| deact_status | output | 1 | Deactivate code detected |
| remote_lpbk | output | 1 | Remote loopback request |
| digital_lpbk | output | 1 | Digital loopback request |
| irq_flags | output | 2 | Sticky interrupt flags (bit 0 activate, bit 1 deactivate) |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The assertions assume a few things about the inputs. Code lengths and patterns stay constant while a code is being tracked. tick_ms is a single-cycle pulse, and the mode inputs change only around a reset. The bench keeps within these limits: it writes every configuration before pulsing reset, drives the tick from a fixed divider of the bit count, and changes only the bit content during a run. Under those conditions the detection time of each status can be predicted exactly from the window length, the starting rotation and the tick schedule. The bench compares that prediction against the status every cycle.

// File: rtl/ibc_pkg.sv
package ibc_pkg;
  // Index of the last code bit for a length select: 00->4 (5 bits) .. 11->7 (8 bits)
  function automatic logic [2:0] code_last(input logic [1:0] sel);
    return 3'd4 + {1'b0, sel};
  endfunction
endpackage

// File: rtl/ibc_matcher.sv
module ibc_matcher
  import ibc_pkg::*;
#(
  parameter int unsigned WIN_BITS = 100,
  parameter int unsigned MAX_ERRS = 1,
  parameter int unsigned TIMER_W  = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_valid,
  input  logic               bit_in,
  input  logic               tick,
  input  logic [1:0]         len_sel,
  input  logic [7:0]         pattern,
  input  logic [TIMER_W-1:0] thr,
  output logic               det
);
  localparam int unsigned BW = $clog2(WIN_BITS);
  localparam int unsigned EW = $clog2(MAX_ERRS + 3);

  logic [2:0]         phase_q, phase_n, last;
  logic [BW-1:0]      bcnt_q, bcnt_n;
  logic [EW-1:0]      errs_q, errs_n, err_sum;
  logic               qual_q, qual_n;
  logic [TIMER_W-1:0] timer_q, timer_n;
  logic               det_q, det_n;
  logic               exp_bit, miss, win_end, bad;

  always_comb begin
    last    = code_last(len_sel);
    exp_bit = pattern[last - phase_q];
    miss    = bit_valid && (bit_in != exp_bit);
    win_end = bit_valid && (bcnt_q == BW'(WIN_BITS - 1));
    err_sum = errs_q + EW'(miss);
    bad     = win_end && (err_sum > EW'(MAX_ERRS));

    phase_n = phase_q;
    bcnt_n  = bcnt_q;
    errs_n  = errs_q;
    qual_n  = qual_q;
    timer_n = timer_q;
    det_n   = det_q;

    if (bit_valid) begin
      if (bad)                  phase_n = phase_q;   // slip one bit
      else if (phase_q >= last) phase_n = 3'd0;
      else                      phase_n = phase_q + 3'd1;
      bcnt_n = win_end ? '0 : bcnt_q + BW'(1);
    end
    if (win_end)                                       errs_n = '0;
    else if (miss && (errs_q <= EW'(MAX_ERRS)))        errs_n = errs_q + EW'(1);
    if (win_end) qual_n = !bad;
    if (bad)                                           timer_n = '0;
    else if (qual_q && tick && (timer_q != '1))        timer_n = timer_q + TIMER_W'(1);
    if (bad)                 det_n = 1'b0;
    else if (timer_q > thr)  det_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      bcnt_q  <= '0;
      errs_q  <= '0;
      qual_q  <= 1'b0;
      timer_q <= '0;
      det_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      bcnt_q  <= bcnt_n;
      errs_q  <= errs_n;
      qual_q  <= qual_n;
      timer_q <= timer_n;
      det_q   <= det_n;
    end
  end

  assign det = det_q;

  p_det_needs_good_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |-> qual_q);
  p_bad_window_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (!det_q && !qual_q && (timer_q == '0)));
  p_timer_idle_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bad) |=> $stable(timer_q));
  p_err_count_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    errs_q <= EW'(MAX_ERRS + 1));
endmodule

// File: rtl/ibc_irq.sv
module ibc_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status,
  input  logic         any_edge,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] prev_q, flags_q, flags_n, set_ev;

  always_comb begin
    set_ev  = (status & ~prev_q) | (any_edge ? (prev_q & ~status) : '0);
    flags_n = set_ev | (flags_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= status;
      flags_q <= flags_n;
    end
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & ~mask);

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_rise_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |=> flags_q[i]);
    p_clear_without_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && $stable(status[i])) |=> !flags_q[i]);
  end
endmodule

// File: rtl/inband_code_detector.sv
module inband_code_detector
  import ibc_pkg::*;
#(
  parameter int unsigned WIN_BITS    = 100,
  parameter int unsigned MAX_ERRS    = 1,
  parameter int unsigned ACT_MS      = 40,
  parameter int unsigned DEACT_T1_MS = 40,
  parameter int unsigned DEACT_E1_MS = 30,
  parameter int unsigned AUTO_MS     = 5100,
  parameter int unsigned TIMER_W     = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_valid,
  input  logic       bit_in,
  input  logic       path_is_tx,
  input  logic       tick_ms,
  input  logic [1:0] act_len,
  input  logic [7:0] act_code,
  input  logic [1:0] deact_len,
  input  logic [7:0] deact_code,
  input  logic       e1_mode,
  input  logic       auto_lpbk,
  input  logic       irq_any_edge,
  input  logic [1:0] irq_mask,
  input  logic [1:0] irq_clr,
  output logic       act_status,
  output logic       deact_status,
  output logic       remote_lpbk,
  output logic       digital_lpbk,
  output logic [1:0] irq_flags,
  output logic       irq
);
  localparam int unsigned NCODE = 2;
  localparam logic [TIMER_W-1:0] ACT_THR = TIMER_W'(ACT_MS);
  localparam logic [TIMER_W-1:0] DT1_THR = TIMER_W'(DEACT_T1_MS);
  localparam logic [TIMER_W-1:0] DE1_THR = TIMER_W'(DEACT_E1_MS);
  localparam logic [TIMER_W-1:0] AUT_THR = TIMER_W'(AUTO_MS);

  logic [1:0]         sel_v [NCODE];
  logic [7:0]         pat_v [NCODE];
  logic [TIMER_W-1:0] thr_v [NCODE];
  logic [NCODE-1:0]   det_v, det_q, rise;
  logic               remote_q, remote_n, digital_q, digital_n;

  always_comb begin
    sel_v[0] = act_len;
    sel_v[1] = deact_len;
    pat_v[0] = act_code;
    pat_v[1] = deact_code;
    thr_v[0] = auto_lpbk ? AUT_THR : ACT_THR;
    thr_v[1] = auto_lpbk ? AUT_THR : (e1_mode ? DE1_THR : DT1_THR);
  end

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    ibc_matcher #(
      .WIN_BITS (WIN_BITS),
      .MAX_ERRS (MAX_ERRS),
      .TIMER_W  (TIMER_W)
    ) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_valid (bit_valid),
      .bit_in    (bit_in),
      .tick      (tick_ms),
      .len_sel   (sel_v[c]),
      .pattern   (pat_v[c]),
      .thr       (thr_v[c]),
      .det       (det_v[c])
    );
  end

  always_comb begin
    rise      = det_v & ~det_q;
    remote_n  = remote_q;
    digital_n = digital_q;
    if (!auto_lpbk) begin
      remote_n  = 1'b0;
      digital_n = 1'b0;
    end else begin
      if (rise[0]) begin
        if (path_is_tx) digital_n = 1'b1;
        else            remote_n  = 1'b1;
      end
      if (rise[1]) begin
        if (path_is_tx) digital_n = 1'b0;
        else            remote_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q     <= '0;
      remote_q  <= 1'b0;
      digital_q <= 1'b0;
    end else begin
      det_q     <= det_v;
      remote_q  <= remote_n;
      digital_q <= digital_n;
    end
  end

  ibc_irq #(.N(NCODE)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (det_v),
    .any_edge (irq_any_edge),
    .clr      (irq_clr),
    .mask     (irq_mask),
    .flags    (irq_flags),
    .irq      (irq)
  );

  assign act_status   = det_v[0];
  assign deact_status = det_v[1];
  assign remote_lpbk  = remote_q;
  assign digital_lpbk = digital_q;

  p_lpbk_off_when_manual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_lpbk |=> (!remote_q && !digital_q));
  p_remote_only_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remote_q) |-> !$past(path_is_tx));
  p_digital_only_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(digital_q) |-> $past(path_is_tx));
  p_masked_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 2'b11) |-> !irq);
endmodule

// File: tb/inband_code_detector_tb.sv
`timescale 1ns/1ps
module inband_code_detector_tb;
  localparam int WIN = 20, MAXE = 1, ACT_T = 3, DT1 = 4, DE1 = 2, AUTO_T = 6, TW = 13, TICKP = 8;

  logic clk = 1'b0;
  logic rst_n, bit_valid, bit_in, path_is_tx, tick_ms, e1_mode, auto_lpbk, irq_any_edge;
  logic [1:0] act_len, deact_len, irq_mask, irq_clr, irq_flags;
  logic [7:0] act_code, deact_code;
  logic act_status, deact_status, remote_lpbk, digital_lpbk, irq;
  int checks = 0, fails = 0, gi = 0;

  always #2.5 clk = ~clk;

  inband_code_detector #(
    .WIN_BITS(WIN), .MAX_ERRS(MAXE), .ACT_MS(ACT_T), .DEACT_T1_MS(DT1),
    .DEACT_E1_MS(DE1), .AUTO_MS(AUTO_T), .TIMER_W(TW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .path_is_tx(path_is_tx), .tick_ms(tick_ms), .act_len(act_len), .act_code(act_code),
    .deact_len(deact_len), .deact_code(deact_code), .e1_mode(e1_mode), .auto_lpbk(auto_lpbk),
    .irq_any_edge(irq_any_edge), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .act_status(act_status), .deact_status(deact_status), .remote_lpbk(remote_lpbk),
    .digital_lpbk(digital_lpbk), .irq_flags(irq_flags), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic code_bit(input logic [7:0] pat, input logic [1:0] sel, input int pos);
    int len = 5 + int'(sel);
    return pat[len - 1 - (pos % len)];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; tick_ms = 1'b0; irq_clr = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    gi = 0;
  endtask

  task automatic step(input logic b);
    bit_valid = 1'b1;
    bit_in    = b;
    tick_ms   = ((gi % TICKP) == TICKP - 1);
    @(posedge clk);
    @(negedge clk);
    gi++;
  endtask

  task automatic idle_clr(input logic [1:0] m);
    irq_clr = m; bit_valid = 1'b0; tick_ms = 1'b0;
    @(posedge clk);
    @(negedge clk);
    irq_clr = 2'b00;
  endtask

  // which: 0 activate code, 1 deactivate code; off: starting rotation of the stream
  task automatic run_det(input int which, input logic [7:0] pat, input logic [1:0] sel, input int off,
                         input int thr, input logic au, input logic e1, input string req);
    int len, eq, n, cnt, bad_i, bad_a, bad_e;
    bit bad, lpbad, tk;
    logic st;
    auto_lpbk = au; e1_mode = e1; path_is_tx = 1'b0; irq_any_edge = 1'b0; irq_mask = 2'b00;
    if (which == 0) begin
      act_code = pat; act_len = sel; deact_code = 8'h00; deact_len = 2'b00;
    end else begin
      deact_code = pat; deact_len = sel; act_code = 8'h00; act_len = 2'b00;
    end
    do_reset();
    len = 5 + int'(sel);
    eq  = (((len - off) % len) + 1) * WIN - 1;
    n   = eq + (thr + 3) * TICKP + 4;
    cnt = 0; bad = 0; lpbad = 0; bad_i = 0; bad_a = 0; bad_e = 0;
    for (int i = 0; i < n; i++) begin
      tk = ((gi % TICKP) == TICKP - 1);
      step(code_bit(pat, sel, i + off));
      st = (which == 0) ? act_status : deact_status;
      if ((st !== (cnt >= thr + 1)) && !bad) begin
        bad = 1; bad_i = i; bad_a = int'(st); bad_e = int'(cnt >= thr + 1);
      end
      if (!au && (remote_lpbk || digital_lpbk)) lpbad = 1;
      if (i > eq && tk) cnt++;
    end
    check(!bad, req, $sformatf("status timeline len=%0d off=%0d thr=%0d cycle=%0d", len, off, thr, bad_i),
          bad_a, bad_e);
    st = (which == 0) ? act_status : deact_status;
    check(st === 1'b1, req, $sformatf("final status len=%0d off=%0d", len, off), int'(st), 1);
    if (!au) check(!lpbad, "R6", "loopback stays off in manual mode", int'(lpbad), 0);
  endtask

  task automatic lb_scenario(input logic tx, input logic anye);
    logic [7:0] ap = 8'hB1, dp = 8'h0F;
    int p0;
    auto_lpbk = 1'b1; e1_mode = 1'b0; path_is_tx = tx; irq_any_edge = anye; irq_mask = 2'b00;
    act_code = ap; act_len = 2'b11; deact_code = dp; deact_len = 2'b00;
    do_reset();
    for (int k = 0; k < 600 && !act_status; k++) step(code_bit(ap, 2'b11, gi));
    step(code_bit(ap, 2'b11, gi));
    step(code_bit(ap, 2'b11, gi));
    check(act_status === 1'b1, "R5", "activate detected in auto mode", int'(act_status), 1);
    check(remote_lpbk === !tx, "R6", "remote request after activate", int'(remote_lpbk), int'(!tx));
    check(digital_lpbk === tx, "R6", "digital request after activate", int'(digital_lpbk), int'(tx));
    check(irq_flags[0] === 1'b1, "R7", "activate flag on rise", int'(irq_flags[0]), 1);
    check(irq === 1'b1, "R8", "irq with mask open", int'(irq), 1);
    irq_mask = 2'b01;
    #1;
    check(irq === 1'b0, "R8", "irq blocked by mask", int'(irq), 0);
    irq_mask = 2'b00;
    idle_clr(2'b01);
    check(irq_flags[0] === 1'b0, "R9", "clear strobe", int'(irq_flags[0]), 0);
    p0 = gi;
    for (int k = 0; k < 800 && !deact_status; k++) step(code_bit(dp, 2'b00, gi - p0));
    step(code_bit(dp, 2'b00, gi - p0));
    step(code_bit(dp, 2'b00, gi - p0));
    check(deact_status === 1'b1, "R5", "deactivate detected in auto mode", int'(deact_status), 1);
    check(act_status === 1'b0, "R3", "activate lost on other code", int'(act_status), 0);
    check(!remote_lpbk && !digital_lpbk, "R6", "requests withdrawn by deactivate",
          int'({remote_lpbk, digital_lpbk}), 0);
    check(irq_flags[1] === 1'b1, "R7", "deactivate flag on rise", int'(irq_flags[1]), 1);
    check(irq_flags[0] === anye, "R7", "activate flag on falling edge per edge select",
          int'(irq_flags[0]), int'(anye));
  endtask

  task automatic tol_scenario();
    logic [7:0] ap = 8'hB1;
    logic b;
    auto_lpbk = 1'b0; e1_mode = 1'b0; path_is_tx = 1'b0; irq_any_edge = 1'b0; irq_mask = 2'b00;
    act_code = ap; act_len = 2'b00; deact_code = 8'h00; deact_len = 2'b00;
    do_reset();
    for (int k = 0; k < 600 && !(act_status && (gi % WIN == 0)); k++) step(code_bit(ap, 2'b00, gi));
    for (int w = 0; w < 3; w++) begin
      for (int j = 0; j < WIN; j++) begin
        b = code_bit(ap, 2'b00, gi);
        step((j == 3) ? ~b : b);
      end
      check(act_status === 1'b1, "R3", $sformatf("one error in window %0d tolerated", w), int'(act_status), 1);
    end
    for (int j = 0; j < WIN; j++) begin
      b = code_bit(ap, 2'b00, gi);
      step((j == 3 || j == 7) ? ~b : b);
      if (j == WIN - 2)
        check(act_status === 1'b1, "R3", "status held before window end", int'(act_status), 1);
    end
    check(act_status === 1'b0, "R3", "two errors clear status at window end", int'(act_status), 0);
  endtask

  task automatic prio_scenario();
    logic [7:0] ap = 8'hB1;
    auto_lpbk = 1'b0; e1_mode = 1'b0; path_is_tx = 1'b0; irq_any_edge = 1'b0; irq_mask = 2'b00;
    act_code = ap; act_len = 2'b00; deact_code = 8'h00; deact_len = 2'b00;
    do_reset();
    irq_clr = 2'b11;
    for (int k = 0; k < 600 && !act_status; k++) step(code_bit(ap, 2'b00, gi));
    step(code_bit(ap, 2'b00, gi));
    check(irq_flags[0] === 1'b1, "R9", "set wins over clear", int'(irq_flags[0]), 1);
    step(code_bit(ap, 2'b00, gi));
    check(irq_flags[0] === 1'b0, "R9", "clear acts next edge", int'(irq_flags[0]), 0);
    irq_clr = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    auto_lpbk = 1'b0; e1_mode = 1'b0; path_is_tx = 1'b0; irq_any_edge = 1'b0; irq_mask = 2'b00;
    act_code = 8'h00; act_len = 2'b00; deact_code = 8'h00; deact_len = 2'b00;
    do_reset();
    // R10 reset state
    check({act_status, deact_status, remote_lpbk, digital_lpbk, irq_flags, irq} === 7'b0, "R10",
          "outputs after reset", int'({act_status, deact_status, remote_lpbk, digital_lpbk, irq_flags, irq}), 0);
    // R1 R2 R4: every length and every starting rotation, manual activate threshold
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 5 + s; o++)
        run_det(0, 8'hB1, 2'(s), o, ACT_T, 1'b0, 1'b0, "R1 R2 R4");
    // R4: deactivate thresholds by framing mode
    for (int s = 0; s < 4; s++) begin
      run_det(1, 8'hB1, 2'(s), 1, DT1, 1'b0, 1'b0, "R4 T1");
      run_det(1, 8'hB1, 2'(s), 2, DE1, 1'b0, 1'b1, "R4 E1");
    end
    // R5: long threshold for both codes
    run_det(0, 8'hB1, 2'b01, 0, AUTO_T, 1'b1, 1'b0, "R5 activate");
    run_det(1, 8'hB1, 2'b10, 3, AUTO_T, 1'b1, 1'b1, "R5 deactivate");
    tol_scenario();
    lb_scenario(1'b0, 1'b0);
    lb_scenario(1'b1, 1'b1);
    prio_scenario();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule